// File: doc/BRIEF.md
# Constant-Rate Secondary Clock Divider with Gear Shift

This block derives a steady 4 MHz secondary clock from a system oscillator whose frequency can be changed while the chip runs. The oscillator may run at a 32 MHz base setting, at a trimmed 24 MHz or 16 MHz setting, or at a 4 MHz low setting that a gear-shift request selects. The block divides the oscillator by the ratio that brings it down to 4 MHz (8, 6 or 4). At the low setting it passes the oscillator through unchanged. Peripherals fed from this output therefore see the same 4 MHz cadence in every power mode, including the stop mode where the oscillator is shifted down to save current.

Besides the clock itself, the block gives a one-source-cycle enable pulse at the start of every output period. Logic that runs on the oscillator clock can use it as a 4 MHz clock enable. A new frequency selection is taken up only at the end of a complete output period, which is the point where the output is about to rise. No high or low phase is ever shortened or stretched. When the divided clock hands over to the direct path, or back, the output is high on both sides of the hand-over, so no edge is added or lost. After reset the divider behaves as if it were at the base setting. It finishes the low half of a divide-by-8 period before it takes up the live selection.

Top module: `gear_clk_div`

## Requirements
- R1: With gearShift low and freqSel = 2'b00 (32 MHz base), clkOut repeats a period of 8 srcClk cycles: high for 4 cycles, then low for 4.
- R2: With gearShift low, freqSel = 2'b01 (24 MHz) gives a period of 6 cycles (3 high, 3 low) and freqSel = 2'b10 (16 MHz) gives a period of 4 cycles (2 high, 2 low). In the divided modes clkOut changes only at rising srcClk edges.
- R3: With gearShift high, whatever freqSel is, clkOut is srcClk itself: high in the high half of each source cycle and low in the low half.
- R4: In the divided modes, enOut is high for exactly one srcClk cycle per output period, and that cycle is the first high cycle of clkOut. While the direct path is selected, enOut is held high.
- R5: The reserved code freqSel = 2'b11 with gearShift low behaves exactly like 2'b00: divide by 8.
- R6: A change of freqSel or gearShift takes effect only at the end of the current output period. That period completes with its old length, the next rising edge of clkOut comes exactly on time, and the following period has the new length. No cycle is added or removed.
- R7: While rstN is low, clkOut and enOut are low. After rstN rises, whatever the inputs, the first rising edge of clkOut, with its enOut pulse, follows the 4th rising srcClk edge. This edge ends the low half of a divide-by-8 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Oscillator clock, at whatever frequency is currently selected |
| rstN | input | 1 | Asynchronous reset, active low |
| freqSel | input | 2 | Oscillator setting: 00 base 32 MHz, 01 24 MHz, 10 16 MHz, 11 reserved (treated as 00) |
| gearShift | input | 1 | High selects the 4 MHz low setting and the direct path, overriding freqSel |
| clkOut | output | 1 | Constant-rate 4 MHz secondary clock |
| enOut | output | 1 | One-source-cycle pulse at each clkOut rising edge; held high in direct mode |

## Verification
The bench builds the block with its default ratios of 8, 6 and 4 and a reset count of half the base ratio, so the period counter is only three bits wide. That small counter brings every ordered pair of the six input settings (four codes, plus gear shift combined with two different codes) within reach of a full sweep. Each pair is switched at every phase offset inside the old period. For each switch the bench counts the cycles left to the next boundary and measures the period that follows, including hand-overs into and out of the direct path. It samples the output in both halves of each source cycle, which shows whether the output changes mid-cycle.

// File: rtl/gear_clk_div_pkg.sv
`timescale 1ns/1ps
package gear_clk_div_pkg;

  // Operating mode held by the control; updated only at a period boundary
  typedef enum logic [1:0] {
    MODE_DIV_BASE = 2'd0,
    MODE_DIV_MID  = 2'd1,
    MODE_DIV_SLOW = 2'd2,
    MODE_PASS     = 2'd3
  } divMode_e;

  // freqSel encodings; anything else falls back to the base setting
  localparam logic [1:0] SEL_MID  = 2'b01;
  localparam logic [1:0] SEL_SLOW = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrap;      // counter at terminal count: restart the period
    logic nextHigh;  // level of the divided output after this edge
    logic passThru;  // route the oscillator straight to the output
  } divStrobe_t;

endpackage

// File: rtl/gear_clk_div_ctrl.sv
`timescale 1ns/1ps
module gear_clk_div_ctrl
  import gear_clk_div_pkg::*;
#(
  parameter int RATIO_BASE = 8,
  parameter int RATIO_MID  = 6,
  parameter int RATIO_SLOW = 4,
  parameter int CNT_W      = $clog2(RATIO_BASE)
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  logic [1:0]       freqSel,
  input  logic             gearShift,
  input  logic [CNT_W-1:0] cntQ,
  output divStrobe_t       strobe
);

  localparam logic [CNT_W:0] LEN_BASE = (CNT_W+1)'(RATIO_BASE);
  localparam logic [CNT_W:0] LEN_MID  = (CNT_W+1)'(RATIO_MID);
  localparam logic [CNT_W:0] LEN_SLOW = (CNT_W+1)'(RATIO_SLOW);
  localparam logic [CNT_W:0] LEN_PASS = (CNT_W+1)'(1);

  divMode_e         modeQ;
  divMode_e         modeReq;
  logic [CNT_W:0]   periodLen;
  logic [CNT_W:0]   cntInc;
  logic             atTerminal;

  // Requested mode from the live inputs; gear shift wins over the code
  always_comb begin
    if (gearShift) begin
      modeReq = MODE_PASS;
    end else begin
      case (freqSel)
        SEL_MID:  modeReq = MODE_DIV_MID;
        SEL_SLOW: modeReq = MODE_DIV_SLOW;
        default:  modeReq = MODE_DIV_BASE;
      endcase
    end
  end

  // Period length of the mode in force
  always_comb begin
    case (modeQ)
      MODE_DIV_MID:  periodLen = LEN_MID;
      MODE_DIV_SLOW: periodLen = LEN_SLOW;
      MODE_PASS:     periodLen = LEN_PASS;
      default:       periodLen = LEN_BASE;
    endcase
  end

  assign cntInc     = {1'b0, cntQ} + (CNT_W+1)'(1);
  assign atTerminal = (cntInc == periodLen);

  // Mode is retargeted only where a new period begins
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_DIV_BASE;
    end else if (atTerminal) begin
      modeQ <= modeReq;
    end
  end

  always_comb begin
    strobe.wrap     = atTerminal;
    strobe.nextHigh = atTerminal || (cntInc < (periodLen >> 1));
    strobe.passThru = (modeQ == MODE_PASS);
  end

endmodule

// File: rtl/gear_clk_div_dpath.sv
`timescale 1ns/1ps
module gear_clk_div_dpath
  import gear_clk_div_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int RESET_CNT = 4
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic             divOut,
  output logic             enOut,
  output logic             clkOut
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RESET_CNT);

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= CNT_RST;
      divOut <= 1'b0;
      enOut  <= 1'b0;
    end else begin
      cntQ   <= strobe.wrap ? '0 : cntQ + CNT_W'(1);
      divOut <= strobe.nextHigh;
      enOut  <= strobe.wrap;
    end
  end

  // divOut is high whenever the direct path is chosen or left, so both
  // mux inputs agree across every hand-over edge
  assign clkOut = strobe.passThru ? srcClk : divOut;

endmodule

// File: rtl/gear_clk_div.sv
`timescale 1ns/1ps
module gear_clk_div
  import gear_clk_div_pkg::*;
#(
  parameter int RATIO_BASE = 8,
  parameter int RATIO_MID  = 6,
  parameter int RATIO_SLOW = 4
) (
  input  logic       srcClk,
  input  logic       rstN,
  input  logic [1:0] freqSel,
  input  logic       gearShift,
  output logic       clkOut,
  output logic       enOut
);

  localparam int CNT_W     = $clog2(RATIO_BASE);
  localparam int RESET_CNT = RATIO_BASE / 2;

  divStrobe_t       strobe;
  logic [CNT_W-1:0] cntQ;
  logic             divOut;
  logic             passThru;

  gear_clk_div_ctrl #(
    .RATIO_BASE(RATIO_BASE),
    .RATIO_MID (RATIO_MID),
    .RATIO_SLOW(RATIO_SLOW),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .srcClk   (srcClk),
    .rstN     (rstN),
    .freqSel  (freqSel),
    .gearShift(gearShift),
    .cntQ     (cntQ),
    .strobe   (strobe)
  );

  gear_clk_div_dpath #(
    .CNT_W    (CNT_W),
    .RESET_CNT(RESET_CNT)
  ) u_dpath (
    .srcClk(srcClk),
    .rstN  (rstN),
    .strobe(strobe),
    .cntQ  (cntQ),
    .divOut(divOut),
    .enOut (enOut),
    .clkOut(clkOut)
  );

  assign passThru = strobe.passThru;

endmodule

// File: rtl/gear_clk_div_chk.sv
`timescale 1ns/1ps
module gear_clk_div_chk #(
  parameter int RATIO_BASE = 8
) (
  input logic clk,
  input logic rstN,
  input logic enOut,
  input logic divOut,
  input logic passThru
);

  localparam int GW = $clog2(RATIO_BASE) + 2;

  logic [GW-1:0] gapQ;
  logic [GW-1:0] hiQ;
  logic [GW-1:0] loQ;
  logic          fullQ;

  // Cycle counters since the last pulse, split into high and low cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapQ  <= '0;
      hiQ   <= '0;
      loQ   <= '0;
      fullQ <= 1'b0;
    end else if (enOut) begin
      gapQ  <= GW'(1);
      hiQ   <= GW'(1);
      loQ   <= '0;
      fullQ <= !passThru;
    end else begin
      if (gapQ != '1) gapQ <= gapQ + GW'(1);
      if (divOut) hiQ <= hiQ + GW'(1);
      else        loQ <= loQ + GW'(1);
    end
  end

  AST_PASS_EN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    passThru |-> enOut); // R4

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && !passThru) |=> (!enOut || passThru)); // R4

  AST_EN_IN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && !passThru) |-> divOut); // R4

  AST_RISE_HAS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (!passThru && $rose(divOut)) |-> enOut); // R4

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (gapQ >= GW'(RATIO_BASE)) |-> enOut); // R6

  AST_DUTY_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && fullQ && !passThru) |-> (hiQ == loQ)); // R2

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(passThru) |-> enOut); // R6

endmodule

bind gear_clk_div gear_clk_div_chk #(
  .RATIO_BASE(RATIO_BASE)
) u_chk (
  .clk     (srcClk),
  .rstN    (rstN),
  .enOut   (enOut),
  .divOut  (divOut),
  .passThru(passThru)
);

// File: tb/tb_gear_clk_div.sv
`timescale 1ns/1ps
module tb_gear_clk_div;

  logic       srcClk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] freqSel = 2'b00;
  logic       gearShift = 1'b0;
  logic       clkOut;
  logic       enOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gear_clk_div dut (
    .srcClk   (srcClk),
    .rstN     (rstN),
    .freqSel  (freqSel),
    .gearShift(gearShift),
    .clkOut   (clkOut),
    .enOut    (enOut)
  );

  always #10 srcClk = ~srcClk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One source cycle: sample 5 ns after the rising edge (high half) and
  // 15 ns after it (low half); returns in the low half
  task automatic step(output bit h, output bit e, output bit l);
    @(posedge srcClk);
    #5;
    h = clkOut;
    e = enOut;
    #10;
    l = clkOut;
  endtask

  // Settings swept: 0..3 freqSel codes, 4 and 5 gear shift with codes 01 / 10
  function automatic int ratioOf(input int cfg);
    case (cfg)
      0: return 8;
      1: return 6;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic string reqOf(input int cfg);
    case (cfg)
      0: return "R1";
      1, 2: return "R2";
      3: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic applyCfg(input int cfg);
    gearShift = (cfg >= 4);
    if (cfg < 4) freqSel = 2'(cfg);
    else freqSel = (cfg == 4) ? 2'b01 : 2'b10;
  endtask

  task automatic seekEn(output bit found, output bit h, output bit l);
    bit e;
    found = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(h, e, l);
      if (e) begin
        found = 1'b1;
        return;
      end
    end
  endtask

  // Starts in an enOut cycle (samples h0/l0); runs to the next enOut cycle
  task automatic measure(input int cfg, input bit h0, input bit l0,
                         output bit hN, output bit lN);
    int per;
    int highs;
    int tog;
    int r;
    bit h;
    bit e;
    bit l;
    r = ratioOf(cfg);
    per = 1;
    highs = h0;
    tog = (h0 != l0);
    hN = 1'b0;
    lN = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(h, e, l);
      if (e) begin
        hN = h;
        lN = l;
        break;
      end
      per++;
      highs += h;
      tog += (h != l);
    end
    check(reqOf(cfg), "period length", per, r);
    if (r > 1) begin
      check(reqOf(cfg), "high cycles", highs, r / 2);
      check(reqOf(cfg), "mid-cycle toggles", tog, 0);
      check("R4", "clkOut high in pulse cycle", h0, 1);
    end else begin
      check(reqOf(cfg), "direct high half", h0, 1);
      check(reqOf(cfg), "direct low half", l0, 0);
    end
  endtask

  initial begin
    bit h;
    bit e;
    bit l;
    bit found;
    int n;
    int tog;

    // R7: reset state and first period after release
    rstN = 1'b0;
    freqSel = 2'b10;
    gearShift = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(h, e, l);
      check("R7", "clkOut during reset", h, 0);
      check("R7", "enOut during reset", e, 0);
    end
    rstN = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      step(h, e, l);
      check("R7", "enOut after release", e, (i == 4) ? 1 : 0);
      check("R7", "clkOut after release", h, (i == 4) ? 1 : 0);
    end
    measure(2, h, l, h, l);

    // R6: every ordered pair of settings, switched at every phase offset
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        for (int off = 0; off < ratioOf(a); off++) begin
          applyCfg(a);
          seekEn(found, h, l);
          check("R6", "boundary reached", found, 1);
          measure(a, h, l, h, l);
          for (int k = 0; k < off; k++) step(h, e, l);
          applyCfg(b);
          n = 0;
          e = 1'b0;
          tog = 0;
          while (!e && n < 20) begin
            step(h, e, l);
            n++;
            if (!e && ratioOf(a) > 1 && h != l) tog++;
          end
          check("R6", "cycles to next boundary", n, ratioOf(a) - off);
          check("R6", "old period toggles", tog, 0);
          measure(b, h, l, h, l);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge srcClk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule